// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold Interrupts

This block holds two byte queues of equal depth: one carries bytes toward a serial engine (transmit) and one carries bytes from it (receive). Each side has an 8-bit trigger level. The transmit side raises a request when its fill drops to its level or below. The receive side raises a ready indication when its fill reaches its level or above. The block also reports empty and full conditions, and flags a write into a full queue or a read from an empty one.

All conditions land in one sticky status word. Software clears bits in that word by writing ones to them. A mask word selects which status bits drive the single interrupt line. Each queue can be emptied through a reset bit in the control word, and that bit clears itself once the flush has taken place. Two event inputs, transfer-complete and chip-select-released, also set sticky status bits, so the whole interrupt picture sits in one place. The register bus decode and the serial engine sit outside this block. They reach it through plain write strobes and push/pop ports.

Top module: `byte_fifo_irq`

## Requirements
- R1: Each queue holds DEPTH (default 64) bytes and returns them in the order they were written. The fill word reports the transmit fill in bits 23:16 and the receive fill in bits 7:0. Every other bit reads 0.
- R2: The control word holds the transmit trigger level in bits 23:16 and the receive trigger level in bits 7:0. Both read back as written.
- R3: Writing control bit 31 flushes the transmit queue, and writing control bit 15 flushes the receive queue. The bit reads 1 in the cycle after the write. Two cycles after the write, the bit reads 0 and the fill is 0. The trigger levels are kept. A flush of one queue leaves the other queue untouched.
- R4: Status bit 1 reflects receive empty, bit 2 receive full, bit 5 transmit empty, and bit 6 transmit full.
- R5: Status bit 4 (transmit request) is set when the transmit fill is at or below the transmit trigger level. Status bit 0 (receive ready) is set when the receive fill is at or above the receive trigger level.
- R6: A push into a full queue is dropped: the fill and the stored bytes are unchanged. The push sets overflow, which is bit 8 for receive and bit 10 for transmit.
- R7: A pop from an empty queue returns 0 and sets underflow, which is bit 9 for receive and bit 11 for transmit.
- R8: A pulse on the transfer-complete input sets status bit 12. A pulse on the chip-select-released input sets status bit 13.
- R9: Status bits are sticky. A status-clear write clears each bit written as 1. If a bit's condition also occurs in the same cycle as the clear, the bit stays set. Bits 3, 7 and 14 to 31 always read 0.
- R10: The interrupt output is high exactly when the status word ANDed with the enable word is nonzero. The enable bits use the same positions as the status bits.
- R11: After reset, both fills are 0 and the control and enable words are 0. One cycle after reset ends, the status word is 0x33.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Control word write strobe |
| cfgWdata | input | 32 | Control word write value |
| cfgWord | output | 32 | Control word readback |
| intEnWe | input | 1 | Enable word write strobe |
| intEnWdata | input | 32 | Enable word write value |
| statClrWe | input | 1 | Status clear strobe |
| statClrData | input | 32 | Ones mark status bits to clear |
| statusWord | output | 32 | Sticky status word |
| fillWord | output | 32 | Both fill counts |
| irq | output | 1 | Interrupt line |
| txPushEn | input | 1 | Write one byte into the transmit queue |
| txPushData | input | 8 | Byte for the transmit queue |
| txPopEn | input | 1 | Take one byte from the transmit queue |
| txPopData | output | 8 | Head of the transmit queue, 0 when empty |
| rxPushEn | input | 1 | Write one byte into the receive queue |
| rxPushData | input | 8 | Byte for the receive queue |
| rxPopEn | input | 1 | Take one byte from the receive queue |
| rxPopData | output | 8 | Head of the receive queue, 0 when empty |
| xferDone | input | 1 | Transfer-complete event |
| csDeassert | input | 1 | Chip-select-released event |

## Verification
Two functions can land in the same cycle: a status-clear write and a fresh event for the same bit. The bench provokes this by writing ones to both underflow bits while it pops the empty receive queue in that same cycle. The receive underflow bit must survive the clear, while the transmit one, which has no new event, must drop. The bench also sweeps both queues through every fill level from 0 to 64 under fixed trigger levels. At each level it computes the expected request, ready, empty and full bits arithmetically and compares them with the status word.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;
  localparam int FILL_W = 8;

  localparam int TX_RST_BIT = 31;
  localparam int RX_RST_BIT = 15;

  localparam int ST_RX_READY = 0;
  localparam int ST_RX_EMPTY = 1;
  localparam int ST_RX_FULL  = 2;
  localparam int ST_TX_REQ   = 4;
  localparam int ST_TX_EMPTY = 5;
  localparam int ST_TX_FULL  = 6;
  localparam int ST_RX_OVF   = 8;
  localparam int ST_RX_UDF   = 9;
  localparam int ST_TX_OVF   = 10;
  localparam int ST_TX_UDF   = 11;
  localparam int ST_DONE     = 12;
  localparam int ST_CS_OFF   = 13;

  localparam logic [31:0] CTRL_MASK = 32'h80FF_80FF;
  localparam logic [31:0] STAT_MASK = 32'h0000_3F77;

  typedef struct packed {
    logic txFlush;
    logic rxFlush;
  } flushStrobe_t;

  typedef struct packed {
    logic [FILL_W-1:0] txFill;
    logic [FILL_W-1:0] rxFill;
    logic txOvf;
    logic txUdf;
    logic rxOvf;
    logic rxUdf;
  } laneReport_t;
endpackage

// File: rtl/byte_fifo_lane.sv
module byte_fifo_lane
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              pushEn,
  input  logic [DATA_W-1:0] pushData,
  input  logic              popEn,
  output logic [DATA_W-1:0] popData,
  output logic [FILL_W-1:0] fill,
  output logic              ovfEvt,
  output logic              udfEvt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic full, empty, pushOk, popOk;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign pushOk = pushEn && !full && !flush;
  assign popOk  = popEn && !empty && !flush;
  assign ovfEvt = pushEn && full;
  assign udfEvt = popEn && empty;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(pushOk) - CW'(popOk);
    end
  end

  assign popData = empty ? '0 : mem[rdPtr];
  assign fill    = FILL_W'(count);
endmodule

// File: rtl/byte_fifo_datapath.sv
module byte_fifo_datapath
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  flushStrobe_t strobe,
  input  logic         txPushEn,
  input  logic [7:0]   txPushData,
  input  logic         txPopEn,
  output logic [7:0]   txPopData,
  input  logic         rxPushEn,
  input  logic [7:0]   rxPushData,
  input  logic         rxPopEn,
  output logic [7:0]   rxPopData,
  output laneReport_t  report
);
  localparam int LANES = 2;
  localparam int RX = 0;
  localparam int TX = 1;

  logic [LANES-1:0] flushV, pushV, popV, ovfV, udfV;
  logic [7:0] pushD [LANES];
  logic [7:0] popD  [LANES];
  logic [FILL_W-1:0] fillV [LANES];

  assign flushV = {strobe.txFlush, strobe.rxFlush};
  assign pushV  = {txPushEn, rxPushEn};
  assign popV   = {txPopEn, rxPopEn};
  assign pushD[RX] = rxPushData;
  assign pushD[TX] = txPushData;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    byte_fifo_lane #(.DEPTH(DEPTH), .DATA_W(8)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .flush    (flushV[g]),
      .pushEn   (pushV[g]),
      .pushData (pushD[g]),
      .popEn    (popV[g]),
      .popData  (popD[g]),
      .fill     (fillV[g]),
      .ovfEvt   (ovfV[g]),
      .udfEvt   (udfV[g])
    );
  end

  assign txPopData     = popD[TX];
  assign rxPopData     = popD[RX];
  assign report.txFill = fillV[TX];
  assign report.rxFill = fillV[RX];
  assign report.txOvf  = ovfV[TX];
  assign report.txUdf  = udfV[TX];
  assign report.rxOvf  = ovfV[RX];
  assign report.rxUdf  = udfV[RX];
endmodule

// File: rtl/byte_fifo_ctrl.sv
module byte_fifo_ctrl
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWe,
  input  logic [31:0]  cfgWdata,
  input  logic         intEnWe,
  input  logic [31:0]  intEnWdata,
  input  logic         statClrWe,
  input  logic [31:0]  statClrData,
  input  logic         xferDone,
  input  logic         csDeassert,
  input  laneReport_t  report,
  output flushStrobe_t strobe,
  output logic [31:0]  cfgWord,
  output logic [31:0]  statusWord,
  output logic         irq
);
  localparam logic [FILL_W-1:0] FULL_FILL = FILL_W'(DEPTH);
  localparam logic [31:0] RST_BITS = (32'd1 << TX_RST_BIT) | (32'd1 << RX_RST_BIT);

  logic [31:0] ctrlQ, ctrlD, enQ, statusQ, statusD, setVec, clrVec;
  logic [7:0] txTrig, rxTrig;

  assign txTrig = ctrlQ[23:16];
  assign rxTrig = ctrlQ[7:0];

  always_comb begin
    ctrlD = ctrlQ & ~RST_BITS;
    if (cfgWe) ctrlD = cfgWdata & CTRL_MASK;
  end

  always_comb begin
    setVec = '0;
    setVec[ST_RX_READY] = (report.rxFill >= rxTrig);
    setVec[ST_RX_EMPTY] = (report.rxFill == '0);
    setVec[ST_RX_FULL]  = (report.rxFill == FULL_FILL);
    setVec[ST_TX_REQ]   = (report.txFill <= txTrig);
    setVec[ST_TX_EMPTY] = (report.txFill == '0);
    setVec[ST_TX_FULL]  = (report.txFill == FULL_FILL);
    setVec[ST_RX_OVF]   = report.rxOvf;
    setVec[ST_RX_UDF]   = report.rxUdf;
    setVec[ST_TX_OVF]   = report.txOvf;
    setVec[ST_TX_UDF]   = report.txUdf;
    setVec[ST_DONE]     = xferDone;
    setVec[ST_CS_OFF]   = csDeassert;
  end

  assign clrVec  = statClrWe ? statClrData : '0;
  assign statusD = ((statusQ & ~clrVec) | setVec) & STAT_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      enQ     <= '0;
      statusQ <= '0;
    end else begin
      ctrlQ   <= ctrlD;
      statusQ <= statusD;
      if (intEnWe) enQ <= intEnWdata & STAT_MASK;
    end
  end

  assign strobe.txFlush = ctrlQ[TX_RST_BIT];
  assign strobe.rxFlush = ctrlQ[RX_RST_BIT];
  assign cfgWord    = ctrlQ;
  assign statusWord = statusQ;
  assign irq        = |(statusQ & enQ);
endmodule

// File: rtl/byte_fifo_irq.sv
module byte_fifo_irq
  import byte_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgWord,
  input  logic        intEnWe,
  input  logic [31:0] intEnWdata,
  input  logic        statClrWe,
  input  logic [31:0] statClrData,
  output logic [31:0] statusWord,
  output logic [31:0] fillWord,
  output logic        irq,
  input  logic        txPushEn,
  input  logic [7:0]  txPushData,
  input  logic        txPopEn,
  output logic [7:0]  txPopData,
  input  logic        rxPushEn,
  input  logic [7:0]  rxPushData,
  input  logic        rxPopEn,
  output logic [7:0]  rxPopData,
  input  logic        xferDone,
  input  logic        csDeassert
);
  flushStrobe_t strobe;
  laneReport_t  report;

  byte_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rstN, .cfgWe, .cfgWdata, .intEnWe, .intEnWdata,
    .statClrWe, .statClrData, .xferDone, .csDeassert,
    .report, .strobe, .cfgWord, .statusWord, .irq
  );

  byte_fifo_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk, .rstN, .strobe,
    .txPushEn, .txPushData, .txPopEn, .txPopData,
    .rxPushEn, .rxPushData, .rxPopEn, .rxPopData,
    .report
  );

  assign fillWord = {8'h00, report.txFill, 8'h00, report.rxFill};
endmodule

// File: rtl/byte_fifo_irq_chk.sv
module byte_fifo_irq_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWe,
  input logic        cfgTxRst,
  input logic        cfgRxRst,
  input logic [31:0] cfgWord,
  input logic        intEnWe,
  input logic [31:0] intEnWdata,
  input logic        statClrWe,
  input logic        clrDoneBit,
  input logic [31:0] statusWord,
  input logic [31:0] fillWord,
  input logic        irq,
  input logic        txPushEn,
  input logic        txPopEn,
  input logic        rxPopEn,
  input logic [7:0]  rxPopData,
  input logic        xferDone
);
  localparam logic [7:0] FULL_FILL = 8'(DEPTH);

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    (fillWord[23:16] <= FULL_FILL) && (fillWord[7:0] <= FULL_FILL));

  assert_tx_flush_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgWord[31] && !(cfgWe && cfgTxRst) |=> !cfgWord[31] && (fillWord[23:16] == 8'd0));

  assert_rx_flush_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgWord[15] && !(cfgWe && cfgRxRst) |=> !cfgWord[15] && (fillWord[7:0] == 8'd0));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    txPushEn && (fillWord[23:16] == FULL_FILL) && !txPopEn && !cfgWord[31]
    |=> (fillWord[23:16] == FULL_FILL) && statusWord[10]);

  assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxPopEn && (fillWord[7:0] == 8'd0) |-> (rxPopData == 8'd0));

  assert_empty_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxPopEn && (fillWord[7:0] == 8'd0) |=> statusWord[9]);

  assert_done_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> statusWord[12]);

  assert_done_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    statClrWe && clrDoneBit && !xferDone |=> !statusWord[12]);

  assert_mask_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    intEnWe && (intEnWdata == 32'd0) |=> !irq);
endmodule

bind byte_fifo_irq byte_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWe      (cfgWe),
  .cfgTxRst   (cfgWdata[31]),
  .cfgRxRst   (cfgWdata[15]),
  .cfgWord    (cfgWord),
  .intEnWe    (intEnWe),
  .intEnWdata (intEnWdata),
  .statClrWe  (statClrWe),
  .clrDoneBit (statClrData[12]),
  .statusWord (statusWord),
  .fillWord   (fillWord),
  .irq        (irq),
  .txPushEn   (txPushEn),
  .txPopEn    (txPopEn),
  .rxPopEn    (rxPopEn),
  .rxPopData  (rxPopData),
  .xferDone   (xferDone)
);

// File: tb/byte_fifo_irq_tb.sv
`timescale 1ns/1ps
module byte_fifo_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int TX_TRIG = 48;
  localparam int RX_TRIG = 16;
  localparam logic [31:0] TRIG_WORD = (32'(TX_TRIG) << 16) | 32'(RX_TRIG);

  logic clk = 0, rstN = 0;
  logic cfgWe = 0, intEnWe = 0, statClrWe = 0;
  logic [31:0] cfgWdata = 0, intEnWdata = 0, statClrData = 0;
  logic [31:0] cfgWord, statusWord, fillWord;
  logic irq;
  logic txPushEn = 0, txPopEn = 0, rxPushEn = 0, rxPopEn = 0;
  logic [7:0] txPushData = 0, rxPushData = 0, txPopData, rxPopData;
  logic xferDone = 0, csDeassert = 0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_fifo_irq #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic pushBoth(input logic [7:0] d);
    txPushEn = 1; rxPushEn = 1; txPushData = d; rxPushData = d;
    step();
    txPushEn = 0; rxPushEn = 0;
  endtask

  task automatic writeCfg(input logic [31:0] v);
    cfgWe = 1; cfgWdata = v; step(); cfgWe = 0;
  endtask

  task automatic clearStat(input logic [31:0] v);
    statClrWe = 1; statClrData = v; step(); statClrWe = 0;
  endtask

  task automatic writeEn(input logic [31:0] v);
    intEnWe = 1; intEnWdata = v; step(); intEnWe = 0;
  endtask

  function automatic logic [31:0] levelBits(input int rxN, input int txN);
    logic [31:0] s = 0;
    s[0] = (rxN >= RX_TRIG);
    s[1] = (rxN == 0);
    s[2] = (rxN == DEPTH);
    s[4] = (txN <= TX_TRIG);
    s[5] = (txN == 0);
    s[6] = (txN == DEPTH);
    return s;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    step(); step();
    // R11 reset state
    chk("R11 fill", fillWord, 32'h0);
    chk("R11 ctrl", cfgWord, 32'h0);
    chk("R11 status", statusWord, 32'h33);
    chk("R11 irq", {31'h0, irq}, 32'h0);

    // R2 trigger levels
    writeCfg(TRIG_WORD);
    chk("R2 ctrl readback", cfgWord, TRIG_WORD);

    // R1 R4 R5 sweep every fill level
    for (int k = 1; k <= DEPTH; k++) begin
      pushBoth(8'(k) ^ 8'h5A);
      step();
      clearStat(32'hFFFF_FFFF);
      chk("R1 fill", fillWord, (32'(k) << 16) | 32'(k));
      chk("R4 R5 levels", statusWord, levelBits(k, k));
    end

    // R6 overflow on full
    pushBoth(8'hEE);
    chk("R6 fill unchanged", fillWord, (32'(DEPTH) << 16) | 32'(DEPTH));
    chk("R6 overflow bits", statusWord & 32'h0F00, 32'h0500);

    // R1 order, R6 no corruption
    for (int k = 1; k <= DEPTH; k++) begin
      chk("R1 tx order", {24'h0, txPopData}, {24'h0, 8'(k) ^ 8'h5A});
      chk("R1 rx order", {24'h0, rxPopData}, {24'h0, 8'(k) ^ 8'h5A});
      txPopEn = 1; rxPopEn = 1; step(); txPopEn = 0; rxPopEn = 0;
    end
    chk("R1 drained", fillWord, 32'h0);

    // R7 empty pop
    txPopEn = 1; rxPopEn = 1;
    chk("R7 tx zero", {24'h0, txPopData}, 32'h0);
    chk("R7 rx zero", {24'h0, rxPopData}, 32'h0);
    step(); txPopEn = 0; rxPopEn = 0;
    chk("R7 underflow bits", statusWord & 32'h0F00, 32'h0F00);

    // R9 clear and fresh rx underflow in the same cycle
    statClrWe = 1; statClrData = 32'h0A00; rxPopEn = 1;
    step(); statClrWe = 0; rxPopEn = 0;
    chk("R9 set wins over clear", statusWord & 32'h0F00, 32'h0700);
    clearStat(32'hFFFF_FFFF);
    chk("R9 cleared", statusWord, levelBits(0, 0));

    // R8 events, sticky
    xferDone = 1; step(); xferDone = 0; step(); step();
    chk("R8 done sticky", statusWord & 32'h3000, 32'h1000);
    csDeassert = 1; step(); csDeassert = 0; step();
    chk("R8 cs sticky", statusWord & 32'h3000, 32'h3000);
    clearStat(32'h0000_3000);
    chk("R9 event clear", statusWord, levelBits(0, 0));

    // R10 interrupt masking
    writeEn(32'h1000);
    chk("R10 masked idle", {31'h0, irq}, 32'h0);
    xferDone = 1; step(); xferDone = 0;
    chk("R10 done irq", {31'h0, irq}, 32'h1);
    clearStat(32'h1000);
    chk("R10 cleared irq", {31'h0, irq}, 32'h0);
    writeEn(32'h0002);
    chk("R10 empty irq", {31'h0, irq}, 32'h1);
    writeEn(32'h0001);
    chk("R10 ready off", {31'h0, irq}, 32'h0);
    writeEn(32'h0);

    // R3 self-clearing flush
    for (int k = 0; k < 5; k++) pushBoth(8'(k));
    writeCfg(TRIG_WORD | 32'h8000_8000);
    chk("R3 bits pending", cfgWord, TRIG_WORD | 32'h8000_8000);
    step();
    chk("R3 bits cleared", cfgWord, TRIG_WORD);
    chk("R3 both flushed", fillWord, 32'h0);
    for (int k = 0; k < 3; k++) pushBoth(8'(k));
    writeCfg(TRIG_WORD | 32'h8000_0000);
    step();
    chk("R3 tx only", fillWord, 32'h0000_0003);
    writeCfg(TRIG_WORD | 32'h0000_8000);
    step();
    chk("R3 rx only", fillWord, 32'h0);
    chk("R3 ctrl kept", cfgWord, TRIG_WORD);

    finishRun();
  end
endmodule